// File: doc/BRIEF.md
# ADC Glitch-Code Rejection Filter

This block sits on the sample stream of a 12-bit successive-approximation converter. It removes isolated wrong codes before the data goes further. A wrong code here is a single sample that jumps by 0xFF or more away from neighbours that agree with each other. Such jumps appear only when the true input sits on one of fifteen major code transitions, and each of those transitions always produces one fixed wrong value.

Every accepted sample moves a three-sample window. The verdict for the middle sample comes out when the next sample arrives, so the filter adds one sample of latency. A best-two-of-three vote decides each output beat:

- If the middle sample agrees with a neighbour, it passes unchanged.
- If the middle sample agrees with neither neighbour but the two neighbours agree, the middle is replaced by the mean of the neighbours and the beat is flagged as rejected.
- If no two samples agree, the middle passes unchanged with a disagreement flag.

A rejected beat is also tagged when the dropped code equals the known wrong value for the transition nearest its neighbours. A sticky flag and a saturating counter record the rejections.

Both stream sides use valid/ready handshakes:

- An input sample is taken on any clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being emptied in the same cycle.
- A pending output beat is held unchanged until `out_ready` takes it.
- While no sample is accepted, the window and all counters hold.

Top module: `adc_glitch_filter`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous reset), the window, counter and flags clear: after that edge `out_valid`=0, `reject_seen`=0, `reject_count`=0 and `in_ready`=1.
- R2: `in_ready` equals `!out_valid || out_ready`. A beat with `out_valid`=1 and `out_ready`=0 keeps `out_valid`, `out_data` and its flags unchanged into the next cycle. A cycle with no accepted input changes neither the window nor the statistics.
- R3: After reset, the first accepted sample yields no beat. The second accepted sample yields a beat carrying the first sample unchanged with all flags 0. From the third accepted sample on, each accepted sample yields the verdict on the previously accepted sample. A beat appears after the edge on which its trigger sample is taken.
- R4: Two codes agree when their absolute difference is below 0xFF (parameter TOL). When the middle sample agrees with at least one neighbour, the beat carries the middle unchanged with `out_reject`=0 and `out_disagree`=0.
- R5: When the middle sample agrees with neither neighbour but the neighbours agree, the beat carries floor((older+newer)/2) with `out_reject`=1 and `out_disagree`=0.
- R6: When no two of the three samples agree, the beat carries the middle unchanged with `out_disagree`=1 and `out_reject`=0.
- R7: `out_sig`=1 only on a rejected beat, and only when the dropped code equals the glitch value G(m).
  - m = floor((mean+0x80)/0x100), where mean is the neighbour mean from R5, and 1 ≤ m ≤ 15.
  - With h = m·0x100 and p the lowest set bit of m: if bit p+1 of m is 1, G(m) is h with bit p+8 cleared. Otherwise G(m) is h with every bit below p+8 set.
  - Examples: G(8)=0xFFF, G(12)=0x800, G(1)=0x1FF, G(3)=0x200, G(5)=0x5FF.
- R8: `reject_seen` goes to 1 on the edge that emits a rejected beat and stays 1 until reset.
- R9: `reject_count` rises by one on the edge that emits each rejected beat. It saturates at 2^CNT_W−1, with CNT_W=16 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Filter can take a sample |
| in_data | input | 12 | Input sample code |
| out_valid | output | 1 | Output beat pending |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 12 | Filtered sample code |
| out_reject | output | 1 | Beat replaced an outlier |
| out_disagree | output | 1 | No two window samples agreed |
| out_sig | output | 1 | Replaced code matched the known glitch value |
| reject_seen | output | 1 | Sticky: some beat was rejected |
| reject_count | output | CNT_W | Saturating reject count |

## Verification
Two pairs of functions can fall in the same cycle:

- A rejection and a signature match can land on the same beat. This is provoked by inserting the exact glitch values for several transitions, including the boundary delta of exactly 0xFF at 0x500/0x5FF, which must both reject and match.
- A rejected beat can arrive while the consumer stalls `out_ready`. The held beat must stay frozen while the statistics advance only once.

A behavioural model in the bench predicts every output bit and both statistics on each clock, and judges both cases. The saturation case is provoked by a narrowed counter fed a repeating agree-agree-outlier pattern.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int DATA_W = 12;
  localparam int TOP_W  = 4;
  localparam int LOW_W  = DATA_W - TOP_W;

  typedef logic [DATA_W-1:0] code_t;

  typedef struct packed {
    code_t value;
    logic  reject;
    logic  disagree;
    logic  sig;
  } verdict_t;

  // Known wrong code produced at the transition into top field m.
  function automatic code_t glitch_of(input logic [TOP_W-1:0] m);
    int    p;
    logic  above;
    code_t hi;
    code_t bitp;
    p = 0;
    for (int i = TOP_W - 1; i >= 0; i--) begin
      if (m[i]) p = i;
    end
    above = 1'b0;
    for (int i = 0; i < TOP_W; i++) begin
      if (i == p + 1) above = m[i];
    end
    hi   = code_t'(m) << LOW_W;
    bitp = code_t'(1) << (p + LOW_W);
    if (above) return hi & ~bitp;
    return hi | (bitp - code_t'(1));
  endfunction
endpackage

// File: rtl/gf_window.sv
module gf_window
  import gf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  code_t      din,
  output code_t      w_old,
  output code_t      w_mid,
  output logic [1:0] fill
);
  localparam logic [1:0] FULL = 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_old <= '0;
      w_mid <= '0;
      fill  <= '0;
    end else if (accept) begin
      w_old <= w_mid;
      w_mid <= din;
      if (fill != FULL) fill <= fill + 2'd1;
    end
  end

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    fill != 2'd3); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(w_mid) && $stable(w_old) && $stable(fill)); // R2
endmodule

// File: rtl/gf_vote.sv
module gf_vote
  import gf_pkg::*;
#(
  parameter int TOL = 255
) (
  input  code_t    a,
  input  code_t    b,
  input  code_t    c,
  output verdict_t v
);
  localparam code_t        TOL_C = code_t'(TOL);
  localparam logic [DATA_W:0] HALF = {{DATA_W{1'b0}}, 1'b1} << (LOW_W - 1);

  function automatic code_t absdiff(input code_t x, input code_t y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  logic           ab_ok, bc_ok, ac_ok;
  code_t          mean;
  logic [TOP_W:0] near;
  logic           near_ok;

  assign ab_ok   = absdiff(a, b) < TOL_C;
  assign bc_ok   = absdiff(b, c) < TOL_C;
  assign ac_ok   = absdiff(a, c) < TOL_C;
  assign mean    = code_t'(({1'b0, a} + {1'b0, c}) >> 1);
  assign near    = (TOP_W+1)'(({1'b0, mean} + HALF) >> LOW_W);
  assign near_ok = !near[TOP_W] && (near[TOP_W-1:0] != '0);

  always_comb begin
    v = '0;
    if (ab_ok || bc_ok) begin
      v.value = b;
    end else if (ac_ok) begin
      v.value  = mean;
      v.reject = 1'b1;
      v.sig    = near_ok && (b == glitch_of(near[TOP_W-1:0]));
    end else begin
      v.value    = b;
      v.disagree = 1'b1;
    end
  end
endmodule

// File: rtl/gf_stats.sv
module gf_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic             seen,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen  <= 1'b0;
      count <= '0;
    end else if (bump) begin
      seen <= 1'b1;
      if (count != MAXV) count <= count + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count == MAXV |=> count == MAXV); // R9
  AST_COUNT_MONO: assert property (@(posedge clk) disable iff (rst)
    !bump |=> $stable(count)); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    seen |=> seen); // R8
endmodule

// File: rtl/adc_glitch_filter.sv
module adc_glitch_filter
  import gf_pkg::*;
#(
  parameter int TOL   = 255,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_reject,
  output logic              out_disagree,
  output logic              out_sig,
  output logic              reject_seen,
  output logic [CNT_W-1:0]  reject_count
);
  logic       accept, emit;
  code_t      w_old, w_mid;
  logic [1:0] fill;
  verdict_t   vote_v, sel, beat;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign emit     = accept && (fill != 2'd0);

  gf_window u_window (
    .clk(clk), .rst(rst), .accept(accept), .din(in_data),
    .w_old(w_old), .w_mid(w_mid), .fill(fill)
  );

  gf_vote #(.TOL(TOL)) u_vote (
    .a(w_old), .b(w_mid), .c(in_data), .v(vote_v)
  );

  always_comb begin
    if (fill == 2'd2) begin
      sel = vote_v;
    end else begin
      sel       = '0;
      sel.value = w_mid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      beat      <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      beat      <= sel;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_data     = beat.value;
  assign out_reject   = beat.reject;
  assign out_disagree = beat.disagree;
  assign out_sig      = beat.sig;

  gf_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .bump(emit && sel.reject),
    .seen(reject_seen), .count(reject_count)
  );

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_reject) && $stable(out_disagree) && $stable(out_sig)); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_reject && out_disagree)); // R6
  AST_SIG_NEEDS_REJECT: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sig |-> out_reject); // R7
  AST_REJECT_STICKS: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_reject |-> reject_seen); // R8
endmodule

// File: tb/tb_adc_glitch_filter.sv
module tb_adc_glitch_filter;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [11:0] in_data = '0;
  logic out_valid, out_ready = 1'b1;
  logic [11:0] out_data;
  logic out_reject, out_disagree, out_sig, reject_seen;
  logic [CW-1:0] reject_count;

  always #5 clk = ~clk;

  adc_glitch_filter #(.TOL(255), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_reject(out_reject), .out_disagree(out_disagree),
    .out_sig(out_sig), .reject_seen(reject_seen), .reject_count(reject_count)
  );

  int errors = 0, checks = 0, cyc = 0, stall = 0;
  bit done = 0;

  // reference model state
  int mfill = 0, mold = 0, mmid = 0, mv = 0, mdata = 0;
  int mrej = 0, mdis = 0, msig = 0, mseen = 0, mcnt = 0, mkind = 3;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int absd(input int x, input int y);
    return (x > y) ? x - y : y - x;
  endfunction

  function automatic int known_glitch(input int m);
    case (m)
      1: return 'h1FF;  2: return 'h3FF;  3: return 'h200;  4: return 'h7FF;
      5: return 'h5FF;  6: return 'h400;  7: return 'h600;  8: return 'hFFF;
      9: return 'h9FF; 10: return 'hBFF; 11: return 'hA00; 12: return 'h800;
     13: return 'hDFF; 14: return 'hC00; 15: return 'hE00;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mfill = 0; mold = 0; mmid = 0; mv = 0; mdata = 0;
      mrej = 0; mdis = 0; msig = 0; mseen = 0; mcnt = 0; mkind = 3;
    end else if (in_valid && (mv == 0 || out_ready)) begin
      int nw;
      nw = int'(in_data);
      if (mfill == 0) begin
        mv = 0;
      end else begin
        mv = 1; mrej = 0; mdis = 0; msig = 0;
        if (mfill == 1) begin
          mdata = mmid; mkind = 3;
        end else if (absd(mold, mmid) < 255 || absd(mmid, nw) < 255) begin
          mdata = mmid; mkind = 4;
        end else if (absd(mold, nw) < 255) begin
          int mean, m;
          mean = (mold + nw) / 2;
          m = (mean + 'h80) / 'h100;
          mdata = mean; mrej = 1; mkind = 5;
          msig = (m >= 1 && m <= 15 && known_glitch(m) == mmid) ? 1 : 0;
          mseen = 1;
          if (mcnt < CMAX) mcnt++;
        end else begin
          mdata = mmid; mdis = 1; mkind = 6;
        end
      end
      mold = mmid; mmid = nw;
      if (mfill < 2) mfill++;
    end else if (out_ready) begin
      mv = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(in_ready == ((mv == 0) || out_ready), "R2 in_ready", int'(in_ready), int'((mv == 0) || out_ready));
      chk(out_valid == (mv != 0), "R3 out_valid", int'(out_valid), mv);
      if (mv != 0) begin
        case (mkind)
          3: chk(int'(out_data) == mdata, "R3 priming data", int'(out_data), mdata);
          4: chk(int'(out_data) == mdata, "R4 pass data", int'(out_data), mdata);
          5: chk(int'(out_data) == mdata, "R5 replaced data", int'(out_data), mdata);
          default: chk(int'(out_data) == mdata, "R6 disagree data", int'(out_data), mdata);
        endcase
        chk(int'(out_reject) == mrej, "R5 reject flag", int'(out_reject), mrej);
        chk(int'(out_disagree) == mdis, "R6 disagree flag", int'(out_disagree), mdis);
        chk(int'(out_sig) == msig, "R7 signature flag", int'(out_sig), msig);
      end
      chk(int'(reject_seen) == mseen, "R8 sticky", int'(reject_seen), mseen);
      chk(int'(reject_count) == mcnt, "R9 count", int'(reject_count), mcnt);
    end
  end

  always @(posedge clk) begin
    #2;
    cyc++;
    if (stall == 0) out_ready = 1'b1;
    else if (stall == 1) out_ready = (cyc % 3) != 0;
    else out_ready = 1'b0;
  end

  task automatic send(input int v);
    bit r;
    in_valid = 1'b1;
    in_data  = 12'(v);
    forever begin
      @(negedge clk); r = in_ready;
      @(posedge clk); #2;
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog R3", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(reject_seen == 1'b0, "R1 sticky", int'(reject_seen), 0);
    chk(reject_count == '0, "R1 count", int'(reject_count), 0);
    @(posedge clk); #2;
    rst = 1'b0;

    // R4: noisy plateau, nothing rejected
    for (int i = 0; i < 10; i++) send('h400 + ((i * 37) % 64) - 32);
    // R5/R7: glitch at the mid-scale transition
    send('h7FF); send('h800); send('hFFF); send('h7FF); send('h800);
    // R5/R7: glitch at the three-quarter transition
    send('hC00); send('hBFF); send('h800); send('hC00); send('hBFF);
    // R5: outlier that is not the known code
    send('h300); send('h300); send('h000); send('h300); send('h300);
    // R4 boundary: delta 0xFE agrees; delta 0xFF rejects and matches
    send('h500); send('h5FE); send('h500); send('h500);
    send('h5FF); send('h500); send('h500);
    // R6: nothing agrees
    send('h000); send('h800); send('hFFF); send('hFFF);
    // R2: irregular back-pressure with outliers
    stall = 1;
    for (int i = 0; i < 12; i++) send((i % 3 == 1) ? 'hE00 : 'h100);
    stall = 0;
    // R2: hard stall while a rejected beat is pending
    send('h200); send('h200); send('hF00);
    fork
      begin stall = 2; repeat (6) @(posedge clk); #3; stall = 0; end
      send('h200);
    join
    send('h200);
    // R2: idle gaps between samples
    send('h6FF); gap(4); send('h700); gap(3); send('h600); gap(2); send('h700);
    // R9: saturation with the agree-agree-outlier pattern
    for (int i = 0; i < 20; i++) begin
      send('h180); send('h180); send('hF80);
    end
    send('h180); send('h180);
    gap(5);
    finish_run();
  end
endmodule